// File: doc/BRIEF.md
# Capability Bounds Expander and Recompressor

This block converts between the compact bounds field of a 64-bit capability word and the pair of wide bounds held in a register file. On the decode path it takes a 4-bit exponent field, a 1-bit shared field, an 8-bit difference mantissa and a 9-bit base mantissa. From these it produces a 41-bit expanded base and a 41-bit expanded top. The top is computed from the base plus a scaled difference, not from a stored top.

On the recompress path it takes an exponent and a pair of 41-bit bounds and extracts the original fields again. A word moved by a capability load followed by a capability store therefore comes back bit for bit, even when it never held a valid capability. This is what allows a plain memory copy to use capability load/store on arbitrary data.

The 41-bit width covers every exponent up to 31 with the same shift-and-add datapath, so no exponent needs a special case. Both paths are purely combinational. The decoded exponent is also exported, so the register file can keep it next to the bounds.

Top module: `cap_bounds_codec`

## Requirements
- R1: The decoded exponent is {exponent field, shared bit} when the 4-bit exponent field is non-zero, and 0 when it is zero. A decoded exponent of 1 cannot be encoded.
- R2: The 9-bit difference is {1, M} when the exponent field is non-zero, and {shared bit, M} when the exponent field is zero.
- R3: The expanded base is the 9-bit base mantissa shifted left by the decoded exponent, zero-extended to 41 bits. Its bits below the exponent are zero.
- R4: The expanded top equals the expanded base plus the difference shifted left by the decoded exponent. It never wraps in 41 bits, even at exponent 31.
- R5: Recompression returns the base mantissa as bits [E+8:E] of the supplied base.
- R6: Recompression returns M as the low 8 bits of (top − base) shifted right by E.
- R7: Recompression returns the exponent field as E[4:1]. The shared bit is returned as E[0] when E[4:1] is non-zero. When E[4:1] is zero, E is treated as 0 and the shared bit is returned as bit 8 of the difference.
- R8: Decoding any field combination and then recompressing the result with the decoded exponent reproduces all four fields exactly.
- R9: All-zero fields decode to a zero base and a zero top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_ef_i | input | 4 | Exponent field of the compressed word |
| dec_me_i | input | 1 | Shared bit: exponent LSB or difference MSB |
| dec_m_i | input | 8 | Difference mantissa |
| dec_b_i | input | 9 | Base mantissa |
| dec_exp_o | output | 5 | Decoded exponent |
| dec_base_o | output | 41 | Expanded base |
| dec_top_o | output | 41 | Expanded top |
| rc_exp_i | input | 5 | Exponent stored with the bounds |
| rc_base_i | input | 41 | Expanded base to recompress |
| rc_top_i | input | 41 | Expanded top to recompress |
| rc_ef_o | output | 4 | Recovered exponent field |
| rc_me_o | output | 1 | Recovered shared bit |
| rc_m_o | output | 8 | Recovered difference mantissa |
| rc_b_o | output | 9 | Recovered base mantissa |

## Verification
Fixed vectors cover four cases. A zero exponent field with the shared bit set shows whether that bit lands in the difference MSB. Exponent 31 with all-ones mantissas shows whether the top bits of the 41-bit bound are kept or truncated. An exponent of 23 shows the case that reaches past bit 32. Random mantissas at every exponent from 0 to 31 are then run through decode and recompress, and mismatched shift amounts show up as round-trip errors. A directed recompress at exponent 1 separates correct folding to exponent 0 from a plain shift by one.

// File: rtl/cbc_pkg.sv
// Package: shared widths for the capability bounds codec.
// Assumes the exponent is the exponent field with one extra low bit.
package cbc_pkg;
    parameter int MANT_W = 9;                          // base mantissa and full difference width
    parameter int EF_W   = 4;                          // stored exponent field width
    localparam int EXP_W = EF_W + 1;                   // decoded exponent width
    localparam int M_W   = MANT_W - 1;                 // stored difference width
    localparam int BND_W = (1 << EXP_W) - 1 + MANT_W + 1; // widest bound, one carry bit spare
endpackage

// File: rtl/cbc_field_split.sv
// Module: splits the stored exponent field, shared bit and difference
// mantissa into a decoded exponent and the full 9-bit difference.
// Assumes a zero exponent field means exponent 0 and frees the shared bit.
module cbc_field_split
    import cbc_pkg::*;
(
    input  logic [EF_W-1:0]   ef_i,
    input  logic              me_i,
    input  logic [M_W-1:0]    m_i,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-1:0] diff_o
);
    logic ef_nz;

    // Purpose: pick the meaning of the shared bit from the exponent field.
    always_comb begin
        ef_nz = (ef_i != '0);
        if (ef_nz) begin
            exp_o  = {ef_i, me_i};
            diff_o = {1'b1, m_i};
        end else begin
            exp_o  = '0;
            diff_o = {me_i, m_i};
        end
    end
endmodule

// File: rtl/cbc_expand.sv
// Module: scales the base mantissa and difference by the exponent and
// forms the wide base and top.
// Assumes BND_W is wide enough that the sum never wraps.
module cbc_expand
    import cbc_pkg::*;
(
    input  logic [MANT_W-1:0] b_i,
    input  logic [MANT_W-1:0] diff_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [BND_W-1:0]  base_o,
    output logic [BND_W-1:0]  top_o
);
    logic [BND_W-1:0] b_wide;
    logic [BND_W-1:0] d_wide;

    // Purpose: zero-extend, shift both mantissas and add for the top.
    always_comb begin
        b_wide = BND_W'(b_i);
        d_wide = BND_W'(diff_i);
        base_o = b_wide << exp_i;
        top_o  = base_o + (d_wide << exp_i);
    end
endmodule

// File: rtl/cbc_recover.sv
// Module: extracts the stored fields back out of a pair of wide bounds.
// Assumes the exponent supplied is the one the bounds were decoded with;
// an exponent whose upper bits are zero is treated as 0.
module cbc_recover
    import cbc_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [BND_W-1:0]  base_i,
    input  logic [BND_W-1:0]  top_i,
    output logic [EF_W-1:0]   ef_o,
    output logic              me_o,
    output logic [M_W-1:0]    m_o,
    output logic [MANT_W-1:0] b_o
);
    logic [EXP_W-1:0] eff_exp;
    logic [BND_W-1:0] unused_base_sh;
    logic [BND_W-1:0] unused_span_sh;

    // Purpose: fold unencodable exponents, then select the mantissas.
    always_comb begin
        ef_o           = exp_i[EXP_W-1:1];
        eff_exp        = (ef_o == '0) ? '0 : exp_i;
        unused_base_sh = base_i >> eff_exp;
        unused_span_sh = (top_i - base_i) >> eff_exp;
        b_o            = unused_base_sh[MANT_W-1:0];
        m_o            = unused_span_sh[M_W-1:0];
        me_o           = (ef_o == '0) ? unused_span_sh[M_W] : exp_i[0];
    end
endmodule

// File: rtl/cap_bounds_codec.sv
// Module: top of the capability bounds codec. Decode path expands the
// stored fields into wide bounds; recompress path recovers the fields.
// Assumes both paths are used combinationally by the register file.
module cap_bounds_codec
    import cbc_pkg::*;
(
    input  logic [EF_W-1:0]   dec_ef_i,
    input  logic              dec_me_i,
    input  logic [M_W-1:0]    dec_m_i,
    input  logic [MANT_W-1:0] dec_b_i,
    output logic [EXP_W-1:0]  dec_exp_o,
    output logic [BND_W-1:0]  dec_base_o,
    output logic [BND_W-1:0]  dec_top_o,
    input  logic [EXP_W-1:0]  rc_exp_i,
    input  logic [BND_W-1:0]  rc_base_i,
    input  logic [BND_W-1:0]  rc_top_i,
    output logic [EF_W-1:0]   rc_ef_o,
    output logic              rc_me_o,
    output logic [M_W-1:0]    rc_m_o,
    output logic [MANT_W-1:0] rc_b_o
);
    logic [MANT_W-1:0] diff;

    cbc_field_split u_split (
        .ef_i   (dec_ef_i),
        .me_i   (dec_me_i),
        .m_i    (dec_m_i),
        .exp_o  (dec_exp_o),
        .diff_o (diff)
    );

    cbc_expand u_expand (
        .b_i    (dec_b_i),
        .diff_i (diff),
        .exp_i  (dec_exp_o),
        .base_o (dec_base_o),
        .top_o  (dec_top_o)
    );

    cbc_recover u_recover (
        .exp_i  (rc_exp_i),
        .base_i (rc_base_i),
        .top_i  (rc_top_i),
        .ef_o   (rc_ef_o),
        .me_o   (rc_me_o),
        .m_o    (rc_m_o),
        .b_o    (rc_b_o)
    );
endmodule

// File: rtl/cap_bounds_codec_chk.sv
// Module: property checker for the codec, attached by bind.
// Assumes settled combinational values; uses immediate assertions only.
module cap_bounds_codec_chk
    import cbc_pkg::*;
(
    input logic [EF_W-1:0]   dec_ef_i,
    input logic              dec_me_i,
    input logic [M_W-1:0]    dec_m_i,
    input logic [MANT_W-1:0] dec_b_i,
    input logic [EXP_W-1:0]  dec_exp_o,
    input logic [BND_W-1:0]  dec_base_o,
    input logic [BND_W-1:0]  dec_top_o,
    input logic [EXP_W-1:0]  rc_exp_i,
    input logic [BND_W-1:0]  rc_base_i,
    input logic [BND_W-1:0]  rc_top_i,
    input logic [EF_W-1:0]   rc_ef_o,
    input logic              rc_me_o,
    input logic [M_W-1:0]    rc_m_o,
    input logic [MANT_W-1:0] rc_b_o
);
    logic [BND_W-1:0] low_mask;
    logic [BND_W-1:0] span_sh;
    logic             same_pair;

    // Purpose: check decode and round-trip properties on every change.
    always_comb begin
        low_mask  = (BND_W'(1) << dec_exp_o) - BND_W'(1);
        span_sh   = (dec_top_o - dec_base_o) >> dec_exp_o;
        same_pair = (rc_exp_i == dec_exp_o) && (rc_base_i == dec_base_o)
                    && (rc_top_i == dec_top_o);
        p_exp_zero_r1: assert ((dec_ef_i != '0) || (dec_exp_o == '0));
        p_top_ge_base_r4: assert (dec_top_o >= dec_base_o);
        p_base_low_zero_r3: assert ((dec_base_o & low_mask) == '0);
        p_diff_msb_r2: assert ((dec_ef_i == '0) || (span_sh[M_W] == 1'b1));
        p_round_trip_r8: assert (!same_pair ||
            ((rc_ef_o == dec_ef_i) && (rc_me_o == dec_me_i) &&
             (rc_m_o == dec_m_i) && (rc_b_o == dec_b_i)));
    end
endmodule

bind cap_bounds_codec cap_bounds_codec_chk u_chk (.*);

// File: tb/cap_bounds_codec_bench.sv
module cap_bounds_codec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  dec_ef_i;
    logic        dec_me_i;
    logic [7:0]  dec_m_i;
    logic [8:0]  dec_b_i;
    logic [4:0]  dec_exp_o;
    logic [40:0] dec_base_o;
    logic [40:0] dec_top_o;
    logic [4:0]  rc_exp_i;
    logic [40:0] rc_base_i;
    logic [40:0] rc_top_i;
    logic [3:0]  rc_ef_o;
    logic        rc_me_o;
    logic [7:0]  rc_m_o;
    logic [8:0]  rc_b_o;

    cap_bounds_codec u_cap_bounds_codec (.*);

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // stimulus {ef, me, m, b} and expected {base, top}
    typedef struct packed {
        logic [3:0]  ef;
        logic        me;
        logic [7:0]  m;
        logic [8:0]  b;
        logic [40:0] base;
        logic [40:0] top;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{4'd0,  1'b0, 8'h00, 9'h000, 41'h0,           41'h0},
        '{4'd0,  1'b1, 8'h00, 9'h001, 41'h1,           41'h101},
        '{4'd1,  1'b0, 8'h00, 9'h003, 41'hC,           41'h40C},
        '{4'd15, 1'b1, 8'hFF, 9'h1FF, 41'hFF80000000,  41'h1FF00000000},
        '{4'd11, 1'b1, 8'h10, 9'h100, 41'h80000000,    41'h108000000},
        '{4'd0,  1'b1, 8'hFF, 9'h1FF, 41'h1FF,         41'h3FE}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] ef, input logic me, input logic [7:0] m, input logic [8:0] b);
        @(negedge clk);
        dec_ef_i = ef; dec_me_i = me; dec_m_i = m; dec_b_i = b;
        #1;
        rc_exp_i = dec_exp_o; rc_base_i = dec_base_o; rc_top_i = dec_top_o;
        #1;
    endtask

    task automatic chk_rt(input logic [3:0] ef, input logic me, input logic [7:0] m, input logic [8:0] b);
        chk("R8 ef", 64'(rc_ef_o), 64'(ef));
        chk("R7 me", 64'(rc_me_o), 64'(me));
        chk("R6 m",  64'(rc_m_o),  64'(m));
        chk("R5 b",  64'(rc_b_o),  64'(b));
    endtask

    initial begin
        dec_ef_i = '0; dec_me_i = 1'b0; dec_m_i = '0; dec_b_i = '0;
        rc_exp_i = '0; rc_base_i = '0; rc_top_i = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R9: idle all-zero fields
        chk("R9 base", 64'(dec_base_o), 64'd0);
        chk("R9 top",  64'(dec_top_o),  64'd0);

        for (int i = 0; i < 6; i++) begin
            drive(VECS[i].ef, VECS[i].me, VECS[i].m, VECS[i].b);
            chk("R3 base", 64'(dec_base_o), 64'(VECS[i].base));
            chk("R4 top",  64'(dec_top_o),  64'(VECS[i].top));
            chk_rt(VECS[i].ef, VECS[i].me, VECS[i].m, VECS[i].b);
        end

        // R1: exponent field/shared-bit mapping
        drive(4'd0, 1'b1, 8'h5A, 9'h0AA);
        chk("R1 exp zero field", 64'(dec_exp_o), 64'd0);
        drive(4'd9, 1'b0, 8'h5A, 9'h0AA);
        chk("R1 exp", 64'(dec_exp_o), 64'd18);
        // R2: implied difference MSB when field non-zero
        chk("R2 diff", 64'((dec_top_o - dec_base_o) >> 18), 64'h15A);

        // Random round trip over every encodable exponent
        for (int e = 0; e < 32; e++) begin
            for (int k = 0; k < 8; k++) begin
                logic [3:0] ef; logic me; logic [7:0] m; logic [8:0] b;
                logic [8:0] d; logic [4:0] ee;
                logic [63:0] eb; logic [63:0] et;
                ef = 4'(e >> 1); me = (ef == 0) ? 1'($urandom) : 1'(e);
                m = 8'($urandom); b = 9'($urandom);
                ee = (ef == 0) ? 5'd0 : {ef, me};
                d = (ef == 0) ? {me, m} : {1'b1, m};
                eb = 64'(b) << ee;
                et = eb + (64'(d) << ee);
                drive(ef, me, m, b);
                chk("R1 exp", 64'(dec_exp_o), 64'(ee));
                chk("R3 base", 64'(dec_base_o), eb);
                chk("R4 top", 64'(dec_top_o), et);
                chk_rt(ef, me, m, b);
            end
        end

        // R7: recompress at exponent 1 folds to exponent 0
        @(negedge clk);
        rc_exp_i = 5'd1; rc_base_i = 41'h0F0; rc_top_i = 41'h1F5;
        #1;
        chk("R7 ef fold", 64'(rc_ef_o), 64'd0);
        chk("R7 me fold", 64'(rc_me_o), 64'd1);
        chk("R6 m fold",  64'(rc_m_o),  64'h05);
        chk("R5 b fold",  64'(rc_b_o),  64'h0F0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule